// File: doc/BRIEF.md
# Watchdog and Low-Voltage Reset Supervisor

This block watches a host processor and pulls a shared, active-low reset line whenever the host needs restarting. It counts ticks from a 100 Hz strobe supplied by the clock divider. If no service strobe arrives within the chosen timeout, it emits a reset pulse of fixed length and then starts timing again. A 2-bit select picks one of three timeouts (25, 75 or 175 ticks, which is 0.25 s, 0.75 s or 1.75 s), or it switches the watchdog off.

The same reset line also follows a supply-below-threshold flag from an external comparator. The line is held low while the flag is set, and for a fixed number of ticks after the flag clears. After a power-on reset of the block, the line stays low for a fixed number of ticks before the host is released.

The output models an open-drain pin. A 0 means the pin is pulled low. A 1 means the pin is released so an external pull-up can raise it. Every pin is a plain control pin: no data stream passes through the block, so it has no valid/ready handshake. Tick and service inputs are single-cycle strobes in the block clock domain.

Top module: `wdsup_top`

## Requirements
- R1: While `arst_n` is low, `rst_out_n` is 0. After `arst_n` rises it stays 0 until POR_TICKS (default 20) ticks have been sampled. It reads 1 in the cycle after the edge that samples the last of those ticks.
- R2: `wd_sel` encodes the timeout: 2'b00 selects T_LONG (175 ticks), 2'b01 selects T_MID (75), 2'b10 selects T_SHORT (25), and 2'b11 turns the watchdog off.
- R3: While the line is released and the watchdog is on, `rst_out_n` falls in the cycle after the edge that samples the N-th tick since the last clear, where N is the selected timeout. The internal count never reaches N.
- R4: A `kick` clears the watchdog count. When `kick` and `tick` occur in the same cycle, the clear wins and the tick is not counted.
- R5: A change in the value of `wd_sel` clears the watchdog count, and the new timeout is then counted from zero.
- R6: A watchdog expiry holds `rst_out_n` low for exactly PULSE_TICKS (default 10) ticks. After that the count restarts from zero under the current select.
- R7: When `low_vdd` is 1, `rst_out_n` is 0 from the next cycle. It stays 0 while `low_vdd` stays 1, and it is released only after LV_TICKS (default 15) ticks sampled with `low_vdd` back at 0.
- R8: With `wd_sel` at 2'b11, no number of ticks causes a watchdog reset.
- R9: A `kick` during a watchdog pulse or a low-voltage hold has no effect: the hold neither lengthens nor shortens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle 100 Hz time-base strobe |
| wd_sel | input | 2 | Watchdog timeout select (see R2) |
| kick | input | 1 | One-cycle watchdog service strobe |
| low_vdd | input | 1 | Supply-below-threshold flag from the comparator |
| rst_out_n | output | 1 | Open-drain reset: 0 pulls low, 1 releases |

## Verification
A wrong watchdog count shows up as a reset edge that arrives some number of ticks early or late. That error becomes visible at the port on the first expiry after the fault, which is at most 175 ticks later. A hold counter that is loaded wrongly or misses a decrement shows up as a wrong pulse, hold or power-on length, and it appears at the next release. A state register stuck in a hold state keeps the line low forever. A fault in select decoding or in the clear path shows up as a timeout that matches a different row of the encoding, or as an expiry in off mode.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  typedef enum logic [1:0] {
    ST_POR,
    ST_RUN,
    ST_PULSE,
    ST_LVHOLD
  } sup_state_e;
endpackage

// File: rtl/wdsup_period_dec.sv
module wdsup_period_dec
  import wdsup_pkg::*;
#(
  parameter int T_SHORT = 25,
  parameter int T_MID   = 75,
  parameter int T_LONG  = 175,
  parameter int CNT_W   = 8
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] limit,
  output logic             enable
);
  always_comb begin
    enable = 1'b1;
    unique case (wd_sel_e'(sel))
      SEL_LONG:  limit = CNT_W'(T_LONG);
      SEL_MID:   limit = CNT_W'(T_MID);
      SEL_SHORT: limit = CNT_W'(T_SHORT);
      default: begin
        limit  = CNT_W'(T_LONG);
        enable = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wdsup_wd_counter.sv
module wdsup_wd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = run && !clr && en && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      cnt <= '0;
    else if (clr || expire)
      cnt <= '0;
    else if (run && en && tick)
      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdsup_hold_timer.sv
module wdsup_hold_timer #(
  parameter int HOLD_W    = 5,
  parameter int RESET_VAL = 20
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              active,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  output logic              done
);
  logic [HOLD_W-1:0] cnt;

  assign done = active && !load && tick && (cnt <= HOLD_W'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      cnt <= HOLD_W'(RESET_VAL);
    else if (load)
      cnt <= load_val;
    else if (active && tick && cnt != '0)
      cnt <= cnt - HOLD_W'(1);
  end
endmodule

// File: rtl/wdsup_top.sv
module wdsup_top
  import wdsup_pkg::*;
#(
  parameter int T_SHORT     = 25,
  parameter int T_MID       = 75,
  parameter int T_LONG      = 175,
  parameter int POR_TICKS   = 20,
  parameter int PULSE_TICKS = 10,
  parameter int LV_TICKS    = 15
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick,
  input  logic [1:0] wd_sel,
  input  logic       kick,
  input  logic       low_vdd,
  output logic       rst_out_n
);
  localparam int T_MAX    = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                             : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
  localparam int H_MAX1   = (POR_TICKS > PULSE_TICKS) ? POR_TICKS : PULSE_TICKS;
  localparam int HOLD_MAX = (H_MAX1 > LV_TICKS) ? H_MAX1 : LV_TICKS;
  localparam int CNT_W    = $clog2(T_MAX + 1);
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  sup_state_e        state_q, state_d;
  logic [1:0]        sel_q;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  wd_cnt;
  logic              wd_en, expire, run, wd_clr, sel_chg;
  logic              hold_load, hold_done;
  logic [HOLD_W-1:0] hold_val;

  assign run       = (state_q == ST_RUN);
  assign sel_chg   = (wd_sel != sel_q);
  assign wd_clr    = kick || sel_chg || !run || low_vdd;
  assign rst_out_n = run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sel_q   <= SEL_LONG;
      state_q <= ST_POR;
    end else begin
      sel_q   <= wd_sel;
      state_q <= state_d;
    end
  end

  wdsup_period_dec #(
    .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .CNT_W(CNT_W)
  ) u_dec (
    .sel(sel_q), .limit(limit), .enable(wd_en)
  );

  wdsup_wd_counter #(.CNT_W(CNT_W)) u_wd (
    .clk(clk), .arst_n(arst_n), .tick(tick), .run(run), .clr(wd_clr),
    .en(wd_en), .limit(limit), .cnt(wd_cnt), .expire(expire)
  );

  wdsup_hold_timer #(.HOLD_W(HOLD_W), .RESET_VAL(POR_TICKS)) u_hold (
    .clk(clk), .arst_n(arst_n), .tick(tick), .active(!run),
    .load(hold_load), .load_val(hold_val), .done(hold_done)
  );

  always_comb begin
    state_d   = state_q;
    hold_load = 1'b0;
    hold_val  = '0;
    if (low_vdd) begin
      state_d   = ST_LVHOLD;
      hold_load = 1'b1;
      hold_val  = HOLD_W'(LV_TICKS);
    end else if (run) begin
      if (expire) begin
        state_d   = ST_PULSE;
        hold_load = 1'b1;
        hold_val  = HOLD_W'(PULSE_TICKS);
      end
    end else if (hold_done) begin
      state_d = ST_RUN;
    end
  end
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             tick,
  input logic             kick,
  input logic             low_vdd,
  input logic             rst_out_n,
  input logic [1:0]       sel_q,
  input logic [CNT_W-1:0] wd_cnt,
  input logic [CNT_W-1:0] limit
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    wd_cnt < limit); // R3

  AST_LV_PULLS_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    low_vdd |=> !rst_out_n); // R7

  AST_KICK_KEEPS_RELEASED: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_out_n && kick && !low_vdd) |=> rst_out_n); // R4

  AST_OFF_NEVER_FIRES: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_out_n && sel_q == 2'b11 && !low_vdd) |=> rst_out_n); // R8

  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_out_n) |-> ($past(low_vdd) || $past(tick))); // R3

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> ($past(tick) && !$past(low_vdd))); // R6
endmodule

bind wdsup_top wdsup_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .tick(tick), .kick(kick), .low_vdd(low_vdd),
  .rst_out_n(rst_out_n), .sel_q(sel_q), .wd_cnt(wd_cnt), .limit(limit)
);

// File: tb/wdsup_top_bench.sv
module wdsup_top_bench;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic       kick = 1'b0;
  logic       low_vdd = 1'b0;
  logic       rst_out_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wdsup_top u_wdsup_top (
    .clk(clk), .arst_n(arst_n), .tick(tick), .wd_sel(wd_sel),
    .kick(kick), .low_vdd(low_vdd), .rst_out_n(rst_out_n)
  );

  // columns: select, kick after this many ticks (0 = none), ticks to expiry
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{2, 0, 25},
    '{1, 0, 75},
    '{0, 0, 175},
    '{2, 20, 45},
    '{1, 50, 125}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  // tick until rst_out_n equals lvl, kicking after kick_at ticks
  task automatic ticks_until(input logic lvl, input int kick_at, input int lim, output int n);
    n = 0;
    while (rst_out_n !== lvl && n < lim) begin
      if (kick_at != 0 && n == kick_at) do_kick();
      pulse_tick();
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state and power-on hold
    repeat (3) @(negedge clk);
    check(rst_out_n === 1'b0, "R1 low in reset", rst_out_n, 0);
    arst_n = 1'b1;
    repeat (19) pulse_tick();
    check(rst_out_n === 1'b0, "R1 still low after 19 ticks", rst_out_n, 0);
    pulse_tick();
    check(rst_out_n === 1'b1, "R1 released after 20 ticks", rst_out_n, 1);

    // R2 R3 R6 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) wd_sel = VEC[i][0][1:0];
      @(negedge clk);
      ticks_until(1'b0, VEC[i][1], 400, n);
      check(n == VEC[i][2], "R2 R3 R4 expiry ticks", n, VEC[i][2]);
      ticks_until(1'b1, 0, 100, n);
      check(n == 10, "R6 pulse length", n, 10);
    end

    // R5: select change restarts the count
    @(negedge clk) wd_sel = 2'b10;
    @(negedge clk);
    repeat (20) pulse_tick();
    @(negedge clk) wd_sel = 2'b01;
    @(negedge clk);
    ticks_until(1'b0, 0, 400, n);
    check(n == 75, "R5 count after select change", n, 75);
    ticks_until(1'b1, 0, 100, n);

    // R4: kick and tick together, kick wins
    @(negedge clk) wd_sel = 2'b10;
    @(negedge clk);
    repeat (24) pulse_tick();
    @(negedge clk) begin tick = 1'b1; kick = 1'b1; end
    @(negedge clk) begin tick = 1'b0; kick = 1'b0; end
    check(rst_out_n === 1'b1, "R4 combined kick tick no expiry", rst_out_n, 1);
    ticks_until(1'b0, 0, 400, n);
    check(n == 25, "R4 count restarted by kick", n, 25);

    // R9: kicks during pulse ignored
    n = 0;
    while (rst_out_n !== 1'b1 && n < 100) begin
      do_kick();
      pulse_tick();
      n++;
    end
    check(n == 10, "R9 pulse not changed by kicks", n, 10);
    ticks_until(1'b0, 0, 400, n);
    check(n == 25, "R6 count restarts after pulse", n, 25);
    ticks_until(1'b1, 0, 100, n);

    // R8: off mode
    @(negedge clk) wd_sel = 2'b11;
    @(negedge clk);
    ticks_until(1'b0, 0, 400, n);
    check(n == 400 && rst_out_n === 1'b1, "R8 off never expires", n, 400);

    // R7: low supply
    @(negedge clk) wd_sel = 2'b10;
    @(negedge clk) low_vdd = 1'b1;
    @(negedge clk);
    check(rst_out_n === 1'b0, "R7 low next cycle", rst_out_n, 0);
    repeat (30) pulse_tick();
    check(rst_out_n === 1'b0, "R7 held while low", rst_out_n, 0);
    @(negedge clk) low_vdd = 1'b0;
    repeat (14) begin do_kick(); pulse_tick(); end
    check(rst_out_n === 1'b0, "R7 R9 still low after 14 ticks", rst_out_n, 0);
    pulse_tick();
    check(rst_out_n === 1'b1, "R7 released after 15 ticks", rst_out_n, 1);
    ticks_until(1'b0, 0, 400, n);
    check(n == 25, "R7 count fresh after hold", n, 25);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule